// File: doc/BRIEF.md
# DMA Address Relocation Map

This block sits between a peripheral bus carrying 18-bit DMA addresses and a main-memory bus that uses 22-bit physical addresses. The 256 KB peripheral space is cut into 32 windows of 8 KB each. The top window is the I/O page, and it never reaches memory. Each of the other 31 windows has a programmable base held in a register pair. When a DMA device issues an address, the block adds the in-window offset to that window's base. It returns the physical address one clock later, together with a flag that says whether the access goes forward to memory.

A CPU-side port loads the register pairs and reads them back. While the map-enable input is low, the block is in pass-through mode. In that mode, windows 0 to 30 fall unchanged onto the low 248 KB of memory, and the I/O page is still held back. Reset clears every pair to zero.

Top module: `dma_reloc_map`

## Requirements
- R1: While reset is asserted, and after it is released, `phys_valid_o`, `phys_fwd_o` and `phys_addr_o` read zero. Every register pair reads back as zero until it is written.
- R2: DMA address bits [17:13] select the window and bits [12:0] give the byte offset inside it.
- R3: With `map_en_i` high and the window in 0..30, `phys_addr_o` equals that window's 22-bit base plus the 13-bit offset, and `phys_fwd_o` is 1.
- R4: `cfg_addr_i[5:1]` selects the pair and `cfg_addr_i[0]` selects the half: 0 is the low half, holding base bits [15:0], and 1 is the high half, holding base bits [21:16] in data bits [5:0]. Bit 0 of the low half is always stored and read back as 0, and the unused upper bits of the high half read 0. `cfg_rdata_o` reflects the current contents with no delay.
- R5: With `map_en_i` low and the window in 0..30, `phys_addr_o` is the DMA address zero-extended to 22 bits, and `phys_fwd_o` is 1.
- R6: An access to window 31 (the I/O page) gives `phys_fwd_o` = 0 and `phys_valid_o` = 1 in both modes, and `phys_addr_o` carries the zero-extended DMA address.
- R7: The outputs appear one clock after `dma_valid_i` is sampled. `phys_valid_o` follows `dma_valid_i`. When no request is present, `phys_fwd_o` is 0 and `phys_addr_o` holds its last value.
- R8: A register write takes effect at the next clock edge. A translation sampled in the same cycle as a write to its own pair uses the old base.
- R9: Writes that select pair 31 are ignored, reads of pair 31 return 0, and pairs 0..30 are not disturbed by such writes.
- R10: The sum of base and offset is truncated to 22 bits, so it wraps around past the top of the 4 MB space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 6 | Pair index [5:1], half select [0] |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data (combinational) |
| map_en_i | input | 1 | 1 = relocate through the map, 0 = pass-through |
| dma_valid_i | input | 1 | DMA address valid |
| dma_addr_i | input | 18 | DMA address from the peripheral bus |
| phys_valid_o | output | 1 | Registered request valid |
| phys_fwd_o | output | 1 | Access goes forward to main memory |
| phys_addr_o | output | 22 | Translated physical address |

## Verification
Register readback has zero latency, so the bench compares `cfg_rdata_o` in the same cycle it drives `cfg_addr_i`. The translated address, the valid bit and the forward flag are due exactly one clock after the request is sampled. The bench therefore computes its expectation from its model state before the edge, lets the edge pass, and only then applies any pending write to the model. It compares the outputs at the following falling edge. This ordering also sets the expected value for a write and a translation to the same pair in one cycle: the old base is due at the output first, and the new base applies from the next request on.

// File: rtl/dma_map_pkg.sv
package dma_map_pkg;
  localparam int unsigned DEV_AW  = 18;
  localparam int unsigned PHYS_AW = 22;
  localparam int unsigned OFF_W   = 13;
  localparam int unsigned LO_W    = 16;
endpackage

// File: rtl/dma_map_regs.sv
module dma_map_regs #(
  parameter int unsigned WIN_W   = 5,
  parameter int unsigned LO_W    = 16,
  parameter int unsigned PHYS_AW = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [WIN_W:0]     cfg_addr_i,
  input  logic [LO_W-1:0]    wdata_i,
  output logic [LO_W-1:0]    rdata_o,
  input  logic [WIN_W-1:0]   win_i,
  output logic [PHYS_AW-1:0] base_o
);
  localparam int unsigned HI_W     = PHYS_AW - LO_W;
  localparam int unsigned NUM_PAIR = (1 << WIN_W) - 1;

  logic [LO_W-1:1]  lo_q [NUM_PAIR];
  logic [HI_W-1:0]  hi_q [NUM_PAIR];
  logic [WIN_W-1:0] sel_idx;
  logic             sel_hi;

  assign sel_idx = cfg_addr_i[WIN_W:1];
  assign sel_hi  = cfg_addr_i[0];

  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
    logic hit;
    assign hit = we_i && (sel_idx == WIN_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (hit) begin
        if (sel_hi) hi_q[g] <= wdata_i[HI_W-1:0];
        else        lo_q[g] <= wdata_i[LO_W-1:1];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(sel_idx) < NUM_PAIR) begin
      if (sel_hi) rdata_o = LO_W'(hi_q[sel_idx]);
      else        rdata_o = {lo_q[sel_idx], 1'b0};
    end
  end

  always_comb begin
    base_o = '0;
    if (int'(win_i) < NUM_PAIR) base_o = {hi_q[win_i], lo_q[win_i], 1'b0};
  end
endmodule

// File: rtl/dma_map_xlate.sv
module dma_map_xlate #(
  parameter int unsigned DEV_AW  = 18,
  parameter int unsigned PHYS_AW = 22,
  parameter int unsigned OFF_W   = 13
) (
  input  logic               map_en_i,
  input  logic [DEV_AW-1:0]  addr_i,
  input  logic [PHYS_AW-1:0] base_i,
  output logic [DEV_AW-OFF_W-1:0] win_o,
  output logic [PHYS_AW-1:0] phys_o,
  output logic               mem_ok_o
);
  localparam int unsigned WIN_W = DEV_AW - OFF_W;

  logic [OFF_W-1:0]   off;
  logic               io_page;
  logic [PHYS_AW-1:0] reloc;
  logic [PHYS_AW-1:0] flat;

  assign win_o   = addr_i[DEV_AW-1:OFF_W];
  assign off     = addr_i[OFF_W-1:0];
  assign io_page = &win_o;
  // sum truncates to PHYS_AW: wraps past top of memory
  assign reloc   = base_i + PHYS_AW'(off);
  assign flat    = PHYS_AW'(addr_i);

  assign phys_o   = (map_en_i && !io_page) ? reloc : flat;
  assign mem_ok_o = !io_page;
endmodule

// File: rtl/dma_reloc_map.sv
module dma_reloc_map #(
  parameter int unsigned DEV_AW  = dma_map_pkg::DEV_AW,
  parameter int unsigned PHYS_AW = dma_map_pkg::PHYS_AW,
  parameter int unsigned OFF_W   = dma_map_pkg::OFF_W,
  parameter int unsigned LO_W    = dma_map_pkg::LO_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [DEV_AW-OFF_W:0] cfg_addr_i,
  input  logic [LO_W-1:0]    cfg_wdata_i,
  output logic [LO_W-1:0]    cfg_rdata_o,
  input  logic               map_en_i,
  input  logic               dma_valid_i,
  input  logic [DEV_AW-1:0]  dma_addr_i,
  output logic               phys_valid_o,
  output logic               phys_fwd_o,
  output logic [PHYS_AW-1:0] phys_addr_o
);
  localparam int unsigned WIN_W = DEV_AW - OFF_W;

  logic [WIN_W-1:0]   win;
  logic [PHYS_AW-1:0] base;
  logic [PHYS_AW-1:0] phys;
  logic               mem_ok;

  dma_map_regs #(.WIN_W(WIN_W), .LO_W(LO_W), .PHYS_AW(PHYS_AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .win_i      (win),
    .base_o     (base)
  );

  dma_map_xlate #(.DEV_AW(DEV_AW), .PHYS_AW(PHYS_AW), .OFF_W(OFF_W)) u_xlate (
    .map_en_i (map_en_i),
    .addr_i   (dma_addr_i),
    .base_i   (base),
    .win_o    (win),
    .phys_o   (phys),
    .mem_ok_o (mem_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phys_valid_o <= 1'b0;
      phys_fwd_o   <= 1'b0;
      phys_addr_o  <= '0;
    end else begin
      phys_valid_o <= dma_valid_i;
      phys_fwd_o   <= dma_valid_i && mem_ok;
      if (dma_valid_i) phys_addr_o <= phys;
    end
  end
endmodule

// File: rtl/dma_map_chk.sv
module dma_map_chk #(
  parameter int unsigned DEV_AW  = 18,
  parameter int unsigned PHYS_AW = 22,
  parameter int unsigned OFF_W   = 13,
  parameter int unsigned LO_W    = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DEV_AW-OFF_W:0] cfg_addr_i,
  input logic [LO_W-1:0]    cfg_rdata_o,
  input logic               map_en_i,
  input logic               dma_valid_i,
  input logic [DEV_AW-1:0]  dma_addr_i,
  input logic               phys_valid_o,
  input logic               phys_fwd_o,
  input logic [PHYS_AW-1:0] phys_addr_o
);
  localparam int unsigned WIN_W = DEV_AW - OFF_W;

  logic io_req;
  assign io_req = dma_valid_i && (&dma_addr_i[DEV_AW-1:OFF_W]);

  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!phys_valid_o && !phys_fwd_o && phys_addr_o == '0);
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_valid_i |=> phys_valid_o);
  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_valid_i |=> (!phys_valid_o && !phys_fwd_o && $stable(phys_addr_o)));
  // R6
  io_page_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req |=> (!phys_fwd_o && phys_valid_o));
  // R6
  fwd_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_fwd_o |-> phys_valid_o);
  // R5
  flat_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_valid_i && !map_en_i && !io_req) |=>
      (phys_fwd_o && phys_addr_o == {{(PHYS_AW-DEV_AW){1'b0}}, $past(dma_addr_i)}));
  // R4
  lo_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_addr_i[0] |-> !cfg_rdata_o[0]);
  // R9
  top_pair_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cfg_addr_i[WIN_W:1]) |-> cfg_rdata_o == '0);
endmodule

bind dma_reloc_map dma_map_chk #(
  .DEV_AW(DEV_AW), .PHYS_AW(PHYS_AW), .OFF_W(OFF_W), .LO_W(LO_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_addr_i   (cfg_addr_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .map_en_i     (map_en_i),
  .dma_valid_i  (dma_valid_i),
  .dma_addr_i   (dma_addr_i),
  .phys_valid_o (phys_valid_o),
  .phys_fwd_o   (phys_fwd_o),
  .phys_addr_o  (phys_addr_o)
);

// File: tb/tb_dma_reloc_map.sv
`timescale 1ns/1ps
module tb_dma_reloc_map;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        map_en_i = 1'b0;
  logic        dma_valid_i = 1'b0;
  logic [17:0] dma_addr_i = '0;
  logic        phys_valid_o;
  logic        phys_fwd_o;
  logic [21:0] phys_addr_o;

  int total = 0;
  int bad = 0;
  int m_lo [31];
  int m_hi [31];
  int exp_hold = 0;

  always #2 clk = ~clk;

  dma_reloc_map dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .map_en_i(map_en_i),
    .dma_valid_i(dma_valid_i), .dma_addr_i(dma_addr_i), .phys_valid_o(phys_valid_o),
    .phys_fwd_o(phys_fwd_o), .phys_addr_o(phys_addr_o)
  );

  task automatic chk(string what, int act, int exp, string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, readback now, outputs at next negedge
  task automatic cyc(bit we, int ca, int wd, bit en, bit v, int a, string tag);
    int idx, half, er, win;
    bit ef;
    cfg_we_i = we; cfg_addr_i = ca[5:0]; cfg_wdata_i = wd[15:0];
    map_en_i = en; dma_valid_i = v; dma_addr_i = a[17:0];
    #0.5;
    idx = (ca >> 1) & 31;
    half = ca & 1;
    er = (idx == 31) ? 0 : (half != 0 ? m_hi[idx] : m_lo[idx]);
    chk("rdata", int'(cfg_rdata_o), er, tag);
    win = (a >> 13) & 31;
    if (v) begin
      if (win == 31 || !en) exp_hold = a & 'h3FFFF;
      else exp_hold = ((m_hi[win] << 16) + m_lo[win] + (a & 'h1FFF)) & 'h3FFFFF;
    end
    ef = v && (win != 31);
    @(posedge clk);
    if (we && idx != 31) begin
      if (half != 0) m_hi[idx] = wd & 'h3F;
      else m_lo[idx] = wd & 'hFFFE;
    end
    @(negedge clk);
    chk("valid", int'(phys_valid_o), int'(v), tag);
    chk("fwd", int'(phys_fwd_o), int'(ef), tag);
    chk("addr", int'(phys_addr_o), exp_hold, tag);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 31; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk("valid", int'(phys_valid_o), 0, "R1");
    chk("fwd", int'(phys_fwd_o), 0, "R1");
    chk("addr", int'(phys_addr_o), 0, "R1");
    rst_ni = 1'b1;
    @(negedge clk);
    cyc(0, 10, 0, 0, 0, 0, "R1");
    cyc(0, 11, 0, 0, 0, 0, "R1");

    // R5 pass-through, R6 I/O page in pass-through
    cyc(0, 0, 0, 0, 1, 'h00000, "R5");
    cyc(0, 0, 0, 0, 1, 'h1E123, "R5");
    cyc(0, 0, 0, 0, 1, 'h3DFFF, "R5");
    cyc(0, 0, 0, 0, 1, 'h3E000, "R6");
    cyc(0, 0, 0, 0, 1, 'h3FFFF, "R6");

    // R4 load all pairs, including odd low values
    for (int i = 0; i < 31; i++) begin
      cyc(1, 2*i,   (i * 'h1235 + 1) & 'hFFFF, 0, 0, 0, "R4");
      cyc(1, 2*i+1, 'hFFC0 | ((i * 5 + 1) & 'h3F), 0, 0, 0, "R4");
    end
    for (int i = 0; i < 62; i++) cyc(0, i, 0, 0, 0, 0, "R4");

    // R9 writes to pair 31 ignored, neighbours intact
    cyc(1, 62, 'hABCD, 0, 0, 0, "R9");
    cyc(1, 63, 'h003F, 0, 0, 0, "R9");
    cyc(0, 62, 0, 0, 0, 0, "R9");
    cyc(0, 63, 0, 0, 0, 0, "R9");
    cyc(0, 60, 0, 0, 0, 0, "R9");
    cyc(0, 61, 0, 0, 0, 0, "R9");

    // R2/R3 every window relocated
    for (int w = 0; w < 31; w++) begin
      cyc(0, 0, 0, 1, 1, (w << 13), "R2/R3");
      cyc(0, 0, 0, 1, 1, (w << 13) | ((w * 'h173) & 'h1FFF), "R2/R3");
      cyc(0, 0, 0, 1, 1, (w << 13) | 'h1FFF, "R2/R3");
    end
    cyc(0, 0, 0, 1, 1, 'h3E000, "R6");
    cyc(0, 0, 0, 1, 1, 'h3F5A5, "R6");

    // R10 wraparound past 4 MB
    cyc(1, 14, 'hFFFF, 1, 0, 0, "R10");
    cyc(1, 15, 'h003F, 1, 0, 0, "R10");
    cyc(0, 14, 0, 1, 1, (7 << 13) | 'h1FFF, "R10");
    cyc(0, 15, 0, 1, 1, (7 << 13) | 'h0002, "R10");

    // R8 same-cycle write uses old base, next uses new
    cyc(1, 6, 'h4000, 1, 1, (3 << 13) | 'h10, "R8");
    cyc(0, 6, 0, 1, 1, (3 << 13) | 'h10, "R8");
    cyc(1, 7, 'h0021, 1, 1, (3 << 13) | 'h20, "R8");
    cyc(0, 7, 0, 1, 1, (3 << 13) | 'h20, "R8");

    // R7 idle cycles hold address, drop valid and fwd
    cyc(0, 0, 0, 1, 0, 'h12345, "R7");
    cyc(0, 0, 0, 1, 0, 'h00000, "R7");
    cyc(0, 0, 0, 1, 1, (5 << 13) | 'h44, "R7");
    cyc(0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, (5 << 13) | 'h44, "R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule